// File: doc/BRIEF.md
# Transmit Power Ramp Sequencer

This block produces the timed strobes that bring a radio transmitter's power amplifier and modulator up before a frame and take them down after it. A transmit request starts a fixed walk through ramp phases. Some phases are fixed counts of system clocks. Others are programmable counts of a bit-time unit, which is a divide-by-20 enable taken from the system clock. Some phases combine the two.

Five internal timing signals come out of the walk: three ramp stages (`t1`, `t2`, `t3`), a transmit-on level and a power-on level. A route-select bit chooses which of these drive the command pin and the power-enable pin. The modulation pin always follows the third ramp stage. Two polarity bits can invert the power-enable pin and the modulation pin. Three live override bits can force any of the three pins. A complementary command output and a data-window strobe complete the outputs.

Timing and routing configuration is captured into shadow registers by a write strobe, and only while the sequencer is idle.

Top module: `txramp_seq`

## Requirements
- R1: After reset the shadow configuration is all zero and the sequencer is idle. `cmd_pin`, `pe_pin`, `mod_pin` and `data_win` are 0, and `cmd_pin_n` is 1.
- R2: Each gap phase lasts N*20 + 2 system clocks, where N is the programmed gap count. N = 0 gives exactly 2 clocks.
- R3: On a request accepted while idle, phases run in this order, starting on the clock edge that samples the request:
  - gap1, with `t1` high;
  - gap2, with `t2` also high;
  - 4 clocks with `t3` also high;
  - 3 clocks with transmit-on also high;
  - the header (hdr*20 clocks), with power-on also high;
  - 2 clocks;
  - the data window (len*20 clocks), with `data_win` high.
- R4: After the data window, the ramp-down runs in this order:
  - gap3, with `t3` still high;
  - gap4, with `t3` low and `t1`, `t2`, transmit-on and power-on still high;
  - 7 clocks with all five internal signals low;
  - a return to idle.
- R5: A header count of 0 or a data count of 0 removes that phase entirely.
- R6: `data_end` high during the data window ends it, and gap3 begins on the next clock.
- R7: With `cfg_route`=0, `cmd_pin` follows transmit-on and the power-enable source is power-on. With `cfg_route`=1, `cmd_pin` follows `t1` and the power-enable source is `t2`.
- R8: `mod_pin` follows `t3` for either routing.
- R9: `pe_pin` is its source XOR `cfg_pe_inv`. `mod_pin` is `t3` XOR `cfg_mod_inv`.
- R10: `cmd_pin_n` is always the inverse of `cmd_pin`.
- R11: Each override bit forces one pin to its `ovr_val` bit, regardless of the sequencer, and takes effect at once: bit 0 is `cmd_pin`, bit 1 is `pe_pin`, bit 2 is `mod_pin`.
- R12: `cfg_we` and `tx_req` have no effect while a sequence is running, including the final 7 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_req | input | 1 | Start request, sampled while idle |
| data_end | input | 1 | Ends the data window early |
| cfg_we | input | 1 | Captures the cfg_* inputs while idle |
| cfg_gap1 | input | 8 | Gap count before t2 rises |
| cfg_gap2 | input | 8 | Gap count before t3 rises |
| cfg_gap3 | input | 8 | Gap count before t3 falls |
| cfg_gap4 | input | 8 | Gap count before t1/t2 fall |
| cfg_hdr_len | input | 8 | Header length in bit units |
| cfg_data_len | input | 12 | Data window length in bit units |
| cfg_route | input | 1 | Pin routing select |
| cfg_pe_inv | input | 1 | Power-enable pin inversion |
| cfg_mod_inv | input | 1 | Modulation pin inversion |
| ovr_en | input | 3 | Per-pin override enable |
| ovr_val | input | 3 | Per-pin override value |
| cmd_pin | output | 1 | Command pin drive |
| cmd_pin_n | output | 1 | Inverse of cmd_pin |
| pe_pin | output | 1 | Power-enable pin drive |
| mod_pin | output | 1 | Modulation pin drive |
| data_win | output | 1 | High during the data window |

## Verification
On every cycle, the assertions check that the ramp stages nest (`t3` implies `t2`, `t2` implies `t1`) and that `t2` rises only after `t1` and outlasts `t3` on the way down. They also check that the data window lies inside transmit-on and power-on, and that the shadow configuration holds still while a sequence runs.

Exact phase lengths can only be shown by the bench's scenarios, which compare every pin cycle by cycle against a model built from the programmed counts. The same holds for the skipping of zero-length phases, early data termination, pin routing, polarity and overrides, and the ignoring of requests and writes made while busy.

// File: rtl/txramp_seq.sv
module txramp_seq #(
  parameter int DIV = 20,
  parameter int GW  = 8,
  parameter int LW  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_req,
  input  logic          data_end,
  input  logic          cfg_we,
  input  logic [GW-1:0] cfg_gap1,
  input  logic [GW-1:0] cfg_gap2,
  input  logic [GW-1:0] cfg_gap3,
  input  logic [GW-1:0] cfg_gap4,
  input  logic [GW-1:0] cfg_hdr_len,
  input  logic [LW-1:0] cfg_data_len,
  input  logic          cfg_route,
  input  logic          cfg_pe_inv,
  input  logic          cfg_mod_inv,
  input  logic [2:0]    ovr_en,
  input  logic [2:0]    ovr_val,
  output logic          cmd_pin,
  output logic          cmd_pin_n,
  output logic          pe_pin,
  output logic          mod_pin,
  output logic          data_win
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int UW = (GW > LW) ? GW : LW;

  typedef enum logic [3:0] {
    S_IDLE, S_G1, S_G2, S_ON4, S_ON3, S_HDR, S_PRE, S_DATA, S_G3, S_G4, S_TAIL
  } st_t;

  st_t st, nst;

  logic [GW-1:0] g1_q, g2_q, g3_q, g4_q, hdr_q;
  logic [LW-1:0] len_q;
  logic          route_q, pinv_q, minv_q;

  logic [2:0]    fix_q, nfix;
  logic [UW-1:0] unit_q, nunit;
  logic [PW-1:0] presc_q;
  logic          last, idle;
  logic          t1, t2, t3, txon, pwr;

  assign idle = (st == S_IDLE);
  assign last = (fix_q == 3'd1 && unit_q == '0) ||
                (fix_q == 3'd0 && unit_q == UW'(1) && presc_q == PW'(DIV - 1));

  always_comb begin
    nst = st;
    unique case (st)
      S_IDLE: if (tx_req) nst = S_G1;
      S_G1:   if (last) nst = S_G2;
      S_G2:   if (last) nst = S_ON4;
      S_ON4:  if (last) nst = S_ON3;
      S_ON3:  if (last) nst = (hdr_q == '0) ? S_PRE : S_HDR;
      S_HDR:  if (last) nst = S_PRE;
      S_PRE:  if (last) nst = (len_q == '0) ? S_G3 : S_DATA;
      S_DATA: if (last || data_end) nst = S_G3;
      S_G3:   if (last) nst = S_G4;
      S_G4:   if (last) nst = S_TAIL;
      S_TAIL: if (last) nst = S_IDLE;
      default: nst = S_IDLE;
    endcase
  end

  always_comb begin
    nfix  = 3'd0;
    nunit = '0;
    unique case (nst)
      S_G1:   begin nfix = 3'd2; nunit = UW'(g1_q); end
      S_G2:   begin nfix = 3'd2; nunit = UW'(g2_q); end
      S_ON4:  nfix = 3'd4;
      S_ON3:  nfix = 3'd3;
      S_HDR:  nunit = UW'(hdr_q);
      S_PRE:  nfix = 3'd2;
      S_DATA: nunit = UW'(len_q);
      S_G3:   begin nfix = 3'd2; nunit = UW'(g3_q); end
      S_G4:   begin nfix = 3'd2; nunit = UW'(g4_q); end
      S_TAIL: nfix = 3'd7;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      fix_q   <= 3'd0;
      unit_q  <= '0;
      presc_q <= '0;
    end else begin
      st <= nst;
      if (nst != st) begin
        fix_q   <= nfix;
        unit_q  <= nunit;
        presc_q <= '0;
      end else if (fix_q != 3'd0) begin
        fix_q <= fix_q - 3'd1;
      end else if (unit_q != '0) begin
        if (presc_q == PW'(DIV - 1)) begin
          presc_q <= '0;
          unit_q  <= unit_q - UW'(1);
        end else begin
          presc_q <= presc_q + PW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g1_q <= '0; g2_q <= '0; g3_q <= '0; g4_q <= '0;
      hdr_q <= '0; len_q <= '0;
      route_q <= 1'b0; pinv_q <= 1'b0; minv_q <= 1'b0;
    end else if (cfg_we && idle) begin
      g1_q <= cfg_gap1; g2_q <= cfg_gap2; g3_q <= cfg_gap3; g4_q <= cfg_gap4;
      hdr_q <= cfg_hdr_len; len_q <= cfg_data_len;
      route_q <= cfg_route; pinv_q <= cfg_pe_inv; minv_q <= cfg_mod_inv;
    end
  end

  assign t1   = (st >= S_G1)  && (st <= S_G4);
  assign t2   = (st >= S_G2)  && (st <= S_G4);
  assign t3   = (st >= S_ON4) && (st <= S_G3);
  assign txon = (st >= S_ON3) && (st <= S_G4);
  assign pwr  = (st >= S_HDR) && (st <= S_G4);
  assign data_win = (st == S_DATA);

  assign cmd_pin   = ovr_en[0] ? ovr_val[0] : (route_q ? t1 : txon);
  assign cmd_pin_n = ~cmd_pin;
  assign pe_pin    = ovr_en[1] ? ovr_val[1] : ((route_q ? t2 : pwr) ^ pinv_q);
  assign mod_pin   = ovr_en[2] ? ovr_val[2] : (t3 ^ minv_q);
endmodule

// File: rtl/txramp_seq_chk.sv
module txramp_seq_chk #(
  parameter int GW = 8,
  parameter int LW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle,
  input logic          t1,
  input logic          t2,
  input logic          t3,
  input logic          txon,
  input logic          pwr,
  input logic          dwin,
  input logic [GW-1:0] g1,
  input logic [GW-1:0] g4,
  input logic [LW-1:0] len,
  input logic          route,
  input logic          pinv
);
  // R3
  t2_in_t1_chk: assert property (@(posedge clk) disable iff (!rst_n) t2 |-> t1);
  // R3
  t3_in_t2_chk: assert property (@(posedge clk) disable iff (!rst_n) t3 |-> t2);
  // R3
  t2_after_t1_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(t2) |-> $past(t1));
  // R4
  t3_drops_first_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(t3) |-> t2);
  // R3
  window_inside_chk: assert property (@(posedge clk) disable iff (!rst_n) dwin |-> (txon && pwr && t3));
  // R12
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !$past(idle)) |-> ($stable(g1) && $stable(g4) && $stable(len) && $stable(route) && $stable(pinv)));
endmodule

bind txramp_seq txramp_seq_chk #(.GW(GW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .t1(t1), .t2(t2), .t3(t3),
  .txon(txon), .pwr(pwr), .dwin(data_win), .g1(g1_q), .g4(g4_q),
  .len(len_q), .route(route_q), .pinv(pinv_q)
);

// File: tb/txramp_seq_tb.sv
module txramp_seq_tb;
  localparam int CLK_P = 10;
  localparam int DIV = 20;

  typedef struct packed {
    int g1; int g2; int g3; int g4; int hdr; int len; int route; int pinv; int minv;
  } scen_t;

  localparam scen_t TBL [6] = '{
    '{1, 1, 1, 1, 2, 3, 0, 0, 0},
    '{0, 2, 0, 1, 1, 2, 1, 0, 0},
    '{2, 0, 1, 0, 0, 2, 0, 1, 1},
    '{1, 1, 2, 2, 1, 0, 1, 1, 0},
    '{3, 1, 1, 1, 1, 4, 0, 0, 1},
    '{0, 0, 0, 0, 0, 0, 1, 1, 1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_req = 1'b0, data_end = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_gap1 = '0, cfg_gap2 = '0, cfg_gap3 = '0, cfg_gap4 = '0, cfg_hdr_len = '0;
  logic [11:0] cfg_data_len = '0;
  logic cfg_route = 1'b0, cfg_pe_inv = 1'b0, cfg_mod_inv = 1'b0;
  logic [2:0] ovr_en = '0, ovr_val = '0;
  logic cmd_pin, cmd_pin_n, pe_pin, mod_pin, data_win;

  int total = 0, bad = 0;
  int lens [1:10];

  always #(CLK_P / 2) clk = ~clk;

  txramp_seq u_dut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .data_end(data_end), .cfg_we(cfg_we),
    .cfg_gap1(cfg_gap1), .cfg_gap2(cfg_gap2), .cfg_gap3(cfg_gap3), .cfg_gap4(cfg_gap4),
    .cfg_hdr_len(cfg_hdr_len), .cfg_data_len(cfg_data_len), .cfg_route(cfg_route),
    .cfg_pe_inv(cfg_pe_inv), .cfg_mod_inv(cfg_mod_inv), .ovr_en(ovr_en), .ovr_val(ovr_val),
    .cmd_pin(cmd_pin), .cmd_pin_n(cmd_pin_n), .pe_pin(pe_pin), .mod_pin(mod_pin),
    .data_win(data_win)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  function automatic int phase_of(input int k);
    int acc = 0;
    for (int p = 1; p <= 10; p++) begin
      if (k < acc + lens[p]) return p;
      acc += lens[p];
    end
    return 0;
  endfunction

  task automatic run_seq(input scen_t s, input int early, input bit wr, input bit disturb, input string tag);
    int tot, dstart, p;
    int mism [5];
    int fa [5];
    int fe [5];
    logic [4:0] ex, ac;
    bit i1, i2, i3, ion, ipw;
    lens[1] = s.g1 * DIV + 2; lens[2] = s.g2 * DIV + 2; lens[3] = 4; lens[4] = 3;
    lens[5] = s.hdr * DIV; lens[6] = 2;
    lens[7] = (early >= 0) ? early + 1 : s.len * DIV;
    lens[8] = s.g3 * DIV + 2; lens[9] = s.g4 * DIV + 2; lens[10] = 7;
    tot = 0;
    for (int q = 1; q <= 10; q++) tot += lens[q];
    dstart = 0;
    for (int q = 1; q <= 6; q++) dstart += lens[q];
    for (int q = 0; q < 5; q++) begin mism[q] = 0; fa[q] = 0; fe[q] = 0; end
    if (wr) begin
      @(negedge clk);
      cfg_gap1 = 8'(s.g1); cfg_gap2 = 8'(s.g2); cfg_gap3 = 8'(s.g3); cfg_gap4 = 8'(s.g4);
      cfg_hdr_len = 8'(s.hdr); cfg_data_len = 12'(s.len);
      cfg_route = s.route[0]; cfg_pe_inv = s.pinv[0]; cfg_mod_inv = s.minv[0];
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
    end
    @(negedge clk);
    tx_req = 1'b1;
    for (int k = 0; k < tot + 4; k++) begin
      @(negedge clk);
      p = phase_of(k);
      i1 = (p >= 1 && p <= 9); i2 = (p >= 2 && p <= 9); i3 = (p >= 3 && p <= 8);
      ion = (p >= 4 && p <= 9); ipw = (p >= 5 && p <= 9);
      ex[0] = s.route[0] ? i1 : ion;
      ex[1] = ~ex[0];
      ex[2] = (s.route[0] ? i2 : ipw) ^ s.pinv[0];
      ex[3] = i3 ^ s.minv[0];
      ex[4] = (p == 7);
      ac = {data_win, mod_pin, pe_pin, cmd_pin_n, cmd_pin};
      for (int q = 0; q < 5; q++)
        if (ac[q] !== ex[q]) begin
          if (mism[q] == 0) begin fa[q] = int'(ac[q]); fe[q] = k; end
          mism[q]++;
        end
      tx_req = disturb && (k == 5 || k == tot - 3);
      data_end = (early >= 0) && (k == dstart + early);
      cfg_we = disturb && (k == 5);
      if (disturb && k == 5) begin
        cfg_gap1 = 8'd7; cfg_gap2 = 8'd7; cfg_gap3 = 8'd7; cfg_gap4 = 8'd7;
        cfg_hdr_len = 8'd7; cfg_data_len = 12'd7;
        cfg_route = ~s.route[0]; cfg_pe_inv = ~s.pinv[0]; cfg_mod_inv = ~s.minv[0];
      end
    end
    tx_req = 1'b0; data_end = 1'b0; cfg_we = 1'b0;
    // fa = first wrong value, fe = cycle of first mismatch
    chk(mism[0] == 0, {"R7 cmd_pin timing/route ", tag}, fa[0], fe[0]);
    chk(mism[1] == 0, {"R10 cmd_pin_n ", tag}, fa[1], fe[1]);
    chk(mism[2] == 0, {"R9 pe_pin timing/polarity ", tag}, fa[2], fe[2]);
    chk(mism[3] == 0, {"R8 mod_pin timing/polarity ", tag}, fa[3], fe[3]);
    chk(mism[4] == 0, {"R3 data_win window ", tag}, fa[4], fe[4]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    scen_t s;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_pin == 1'b0, "R1 cmd_pin reset", int'(cmd_pin), 0);
    chk(cmd_pin_n == 1'b1, "R1 cmd_pin_n reset", int'(cmd_pin_n), 1);
    chk(pe_pin == 1'b0, "R1 pe_pin reset", int'(pe_pin), 0);
    chk(mod_pin == 1'b0, "R1 mod_pin reset", int'(mod_pin), 0);
    chk(data_win == 1'b0, "R1 data_win reset", int'(data_win), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R7 R8 R9 over the table
    for (int i = 0; i < 6; i++) begin
      s = TBL[i];
      run_seq(s, -1, 1'b1, 1'b0, $sformatf("R2 R4 R5 table row %0d", i));
    end

    // R6 early end of data window, mid-window and on its first cycle
    s = TBL[4];
    run_seq(s, 10, 1'b1, 1'b0, "R6 early end at 10");
    run_seq(s, 0, 1'b1, 1'b0, "R6 early end at 0");

    // R12 writes and requests while busy are ignored, also in the tail
    s = TBL[0];
    run_seq(s, -1, 1'b1, 1'b1, "R12 busy writes");
    run_seq(s, -1, 1'b0, 1'b0, "R12 old config kept");

    // R11 overrides while idle (shadow from TBL[0]: no inversion)
    @(negedge clk);
    ovr_en = 3'b111; ovr_val = 3'b101;
    #1;
    chk(cmd_pin == 1'b1, "R11 cmd override", int'(cmd_pin), 1);
    chk(cmd_pin_n == 1'b0, "R10 cmd_pin_n under override", int'(cmd_pin_n), 0);
    chk(pe_pin == 1'b0, "R11 pe override", int'(pe_pin), 0);
    chk(mod_pin == 1'b1, "R11 mod override", int'(mod_pin), 1);
    ovr_en = 3'b010; ovr_val = 3'b010;
    #1;
    chk(pe_pin == 1'b1, "R11 pe override alone", int'(pe_pin), 1);
    chk(cmd_pin == 1'b0, "R11 cmd not overridden", int'(cmd_pin), 0);
    chk(mod_pin == 1'b0, "R11 mod not overridden", int'(mod_pin), 0);
    ovr_en = 3'b000; ovr_val = 3'b000;
    #1;
    chk(pe_pin == 1'b0, "R11 override released", int'(pe_pin), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule